// File: doc/BRIEF.md
# Configurable SPI Master/Slave Port

This block is a serial peripheral interface port that works either as the bus master, generating the serial clock, or as a slave clocked from outside. A single mode input chooses the role. Both roles share one shift path, so clock polarity, clock phase, a word length of 8 or 16 bits and the choice between least-significant-first and most-significant-first ordering apply the same way in each role.

Software writes a transmit word through a parallel data port, reads the received word from a parallel output, and observes a sticky completion flag that stays set until a clear strobe is pulsed. An interrupt output follows the flag, gated by an interrupt-enable input. In master mode, writing a transmit word while the port is idle starts a transfer, and a divisor sets the serial clock rate. In slave mode, a transfer begins when the active-low select input falls, and the external serial clock, the incoming data pin and the select input each pass through two-stage synchronisers before the port uses them.

Top module: `spiPort`

## Requirements
- R1: In master mode the port drives `sckOut` at the level of `cpol` while idle. During a transfer it toggles `sckOut` once every `baudDiv+1` system clocks and makes exactly 2×N toggles, where N is 8 when `wide`=0 and 16 when `wide`=1. It then returns to the idle level.
- R2: The outgoing bit sequence is the low N bits of the transmit word. It is sent bit N-1 first when `lsbFirst`=0 and bit 0 first when `lsbFirst`=1.
- R3: With `cpha`=0, the first bit is on the data output before the first clock edge, data is sampled on the edge that leaves the idle level, and data changes on the edge that returns to it. With `cpha`=1, data changes on the leaving edge and is sampled on the returning edge. The same edges apply in both roles.
- R4: In slave mode (`masterSel`=0) the port never drives `sckOe` or `mosiOe`, and a transmit write alone never starts a transfer or sets the flag. `misoOe` is high only while the port is enabled and the synchronised select is low.
- R5: A slave transfer happens only while `enable`=1 and `ssN` is low. With `enable`=0, clocking the select and clock pins sets no flag and leaves `misoOe` low.
- R6: `baudDiv` has no effect in slave mode. Slave transfers give the same data and flag result for any divisor value.
- R7: `doneFlag` sets after a full N-bit word has been exchanged. `rxData` then holds the received word, with bits 15..8 zero when `wide`=0. The flag stays set until `flagClear` is pulsed.
- R8: `irq` is high exactly while `doneFlag` is set and `irqEnable`=1.
- R9: If `ssN` rises before a slave word is complete, the partial word is discarded: no flag is set, `rxData` keeps its previous value, and the next transfer starts from its first bit.
- R10: A transmit word written while the port is idle is loaded into the shifter at the next transfer start. In master mode the write itself starts the transfer. In slave mode the word is loaded at the next falling edge of the select.
- R11: After reset, `doneFlag`, `irq`, `rxData` and all output enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable |
| masterSel | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| lsbFirst | input | 1 | 1 = least significant bit first |
| irqEnable | input | 1 | Interrupt enable |
| baudDiv | input | 8 | Master clock divisor; half period is baudDiv+1 clocks |
| txData | input | 16 | Transmit word |
| txWrite | input | 1 | Strobe that writes txData |
| flagClear | input | 1 | Strobe that clears the completion flag |
| rxData | output | 16 | Last complete received word |
| doneFlag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| sckIn | input | 1 | Serial clock pin input (slave) |
| sckOut | output | 1 | Serial clock pin output (master) |
| sckOe | output | 1 | Serial clock output enable |
| mosiIn | input | 1 | Master-out pin input (slave data in) |
| mosiOut | output | 1 | Master-out pin output (master data out) |
| mosiOe | output | 1 | Master-out output enable |
| misoIn | input | 1 | Master-in pin input (master data in) |
| misoOut | output | 1 | Master-in pin output (slave data out) |
| misoOe | output | 1 | Master-in output enable |
| ssN | input | 1 | Active-low slave select |

## Verification
The hardest case to reach is a slave word cut off part way through. The bench must lower the select, deliver only a few clock edges through the synchronisers, and raise the select before the count reaches the word length. It then has to show, from the ports alone, that the flag stayed clear and the received word did not change, and that a following complete transfer still lines up on its first bit. The bench plays the far end of the bus in both roles. As master, it watches the generated clock and answers on the data-in pin edge by edge. As slave, it drives clock, data and select itself with slow half periods. It sweeps every combination of polarity, phase, word size and bit order in each role, with divisors that vary between runs.

// File: rtl/spiPkg.sv
package spiPkg;
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic capture;
    logic inBit;
  } spiStrobeT;
endpackage

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         strb,
  input  logic              wide,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic              outBit,
  output logic [DATA_W-1:0] rxData
);
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] txSr;
  logic [DATA_W-1:0] rxSr;
  logic [DATA_W-1:0] rxShr;
  logic [DATA_W-1:0] rxNext;
  logic [DATA_W-1:0] rxWord;

  always_comb begin
    rxShr = rxSr >> 1;
    if (wide) rxShr[DATA_W-1] = strb.inBit;
    else      rxShr[SHORT_W-1] = strb.inBit;
    rxNext = lsbFirst ? rxShr : {rxSr[DATA_W-2:0], strb.inBit};
    rxWord = strb.sample ? rxNext : rxSr;
  end

  assign outBit = lsbFirst ? txSr[0] : (wide ? txSr[DATA_W-1] : txSr[SHORT_W-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
      txSr    <= '0;
      rxSr    <= '0;
      rxData  <= '0;
    end else begin
      if (txWrite) holdReg <= txData;
      if (strb.load) begin
        txSr <= holdReg;
        rxSr <= '0;
      end else begin
        if (strb.shift)  txSr <= lsbFirst ? (txSr >> 1) : (txSr << 1);
        if (strb.sample) rxSr <= rxNext;
      end
      if (strb.capture) rxData <= wide ? rxWord : (rxWord & NARROW_MASK);
    end
  end

  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.load)) |-> txSr == $past(holdReg));

  // R7
  narrow_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.capture) && !$past(wide)) |-> rxData[DATA_W-1:SHORT_W] == '0);
endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             masterSel,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             wide,
  input  logic             irqEnable,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             txWrite,
  input  logic             flagClear,
  input  logic             sckIn,
  input  logic             mosiIn,
  input  logic             misoIn,
  input  logic             ssN,
  output spiStrobeT        strb,
  output logic             sckOut,
  output logic             sckOe,
  output logic             mosiOe,
  output logic             misoOe,
  output logic             doneFlag,
  output logic             irq
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int TGL_W = CNT_W + 1;

  logic sckS1, sckS2, sckS3;
  logic mosiS1, mosiS2;
  logic ssS1, ssS2, ssS3;

  logic             busy;
  logic             pendStart;
  logic             sckReg;
  logic             flag;
  logic [CNT_W-1:0] bitCnt;
  logic [TGL_W-1:0] tglCnt;
  logic [DIV_W-1:0] divCnt;

  logic [CNT_W-1:0] wordLen;
  logic [TGL_W-1:0] tglLast;
  logic masterOn, slaveOn;
  logic ssFall, ssRise;
  logic sckEdge, slvLead, slvTrail;
  logic tick, mstLead, mstTrail;
  logic leadEv, trailEv, sampleEv, shiftEv;
  logic doneEv, abortEv, loadEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckS1 <= 1'b0; sckS2 <= 1'b0; sckS3 <= 1'b0;
      mosiS1 <= 1'b0; mosiS2 <= 1'b0;
      ssS1 <= 1'b1; ssS2 <= 1'b1; ssS3 <= 1'b1;
    end else begin
      sckS1 <= sckIn;  sckS2 <= sckS1;  sckS3 <= sckS2;
      mosiS1 <= mosiIn; mosiS2 <= mosiS1;
      ssS1 <= ssN;     ssS2 <= ssS1;    ssS3 <= ssS2;
    end
  end

  always_comb begin
    wordLen  = wide ? CNT_W'(DATA_W) : CNT_W'(SHORT_W);
    tglLast  = {wordLen, 1'b0} - TGL_W'(1);
    masterOn = enable && masterSel;
    slaveOn  = enable && !masterSel;
    ssFall   = ssS3 && !ssS2;
    ssRise   = !ssS3 && ssS2;

    sckEdge  = sckS2 ^ sckS3;
    slvLead  = sckEdge && (sckS2 ^ cpol);
    slvTrail = sckEdge && !(sckS2 ^ cpol);

    tick     = busy && masterOn && (divCnt == baudDiv);
    mstLead  = tick && (sckReg == cpol);
    mstTrail = tick && (sckReg != cpol);

    if (masterSel) begin
      leadEv  = mstLead;
      trailEv = mstTrail;
    end else begin
      leadEv  = slvLead && busy && slaveOn && !ssS2;
      trailEv = slvTrail && busy && slaveOn && !ssS2;
    end

    sampleEv = cpha ? trailEv : leadEv;
    shiftEv  = cpha ? (leadEv && bitCnt != '0) : trailEv;

    if (masterSel) doneEv = tick && (tglCnt == tglLast);
    else           doneEv = sampleEv && (bitCnt == wordLen - CNT_W'(1));

    abortEv = busy && slaveOn && ssRise;
    loadEv  = masterSel ? pendStart : (slaveOn && ssFall);

    strb.load    = loadEv;
    strb.sample  = sampleEv;
    strb.shift   = shiftEv;
    strb.capture = doneEv;
    strb.inBit   = masterSel ? misoIn : mosiS2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      pendStart <= 1'b0;
      sckReg    <= 1'b0;
      flag      <= 1'b0;
      bitCnt    <= '0;
      tglCnt    <= '0;
      divCnt    <= '0;
    end else begin
      pendStart <= txWrite && masterOn && !busy && !pendStart;

      if (!enable)               busy <= 1'b0;
      else if (loadEv)           busy <= 1'b1;
      else if (doneEv || abortEv) busy <= 1'b0;

      if (loadEv)        bitCnt <= '0;
      else if (sampleEv) bitCnt <= bitCnt + CNT_W'(1);

      if (loadEv) begin
        divCnt <= '0;
        tglCnt <= '0;
      end else if (busy && masterOn) begin
        if (divCnt == baudDiv) begin
          divCnt <= '0;
          tglCnt <= tglCnt + TGL_W'(1);
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end

      if (!busy || !masterOn) sckReg <= cpol;
      else if (tick)          sckReg <= ~sckReg;

      if (doneEv)         flag <= 1'b1;
      else if (flagClear) flag <= 1'b0;
    end
  end

  assign sckOut   = sckReg;
  assign sckOe    = masterOn;
  assign mosiOe   = masterOn;
  assign misoOe   = slaveOn && !ssS2;
  assign doneFlag = flag;
  assign irq      = flag && irqEnable;

  // R1
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !busy && !$past(busy) && $stable(cpol)) |-> sckReg == cpol);

  // R1
  div_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && busy && $past(busy) && masterSel && sckReg != $past(sckReg))
      |-> $past(divCnt) == $past(baudDiv));

  // R7
  bit_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(DATA_W));

  // R9
  slave_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && slaveOn && ssRise) |=> !busy);

  // R4
  slave_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !masterSel) |-> !ssS2);
endmodule

// File: rtl/spiPort.sv
module spiPort
  import spiPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHORT_W = 8,
  parameter int DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              masterSel,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              wide,
  input  logic              lsbFirst,
  input  logic              irqEnable,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              flagClear,
  output logic [DATA_W-1:0] rxData,
  output logic              doneFlag,
  output logic              irq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);
  spiStrobeT strb;
  logic      outBit;

  spiCtrl #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .masterSel(masterSel),
    .cpol(cpol), .cpha(cpha), .wide(wide), .irqEnable(irqEnable),
    .baudDiv(baudDiv), .txWrite(txWrite), .flagClear(flagClear),
    .sckIn(sckIn), .mosiIn(mosiIn), .misoIn(misoIn), .ssN(ssN),
    .strb(strb), .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe),
    .misoOe(misoOe), .doneFlag(doneFlag), .irq(irq)
  );

  spiDatapath #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wide(wide), .lsbFirst(lsbFirst),
    .txData(txData), .txWrite(txWrite), .outBit(outBit), .rxData(rxData)
  );

  assign mosiOut = outBit;
  assign misoOut = outBit;
endmodule

// File: tb/tb_spiPort.sv
`timescale 1ns/1ps
module tb_spiPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, masterSel = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic wide = 1'b0, lsbFirst = 1'b0, irqEnable = 1'b0;
  logic [7:0]  baudDiv = '0;
  logic [15:0] txData = '0;
  logic txWrite = 1'b0, flagClear = 1'b0;
  logic [15:0] rxData;
  logic doneFlag, irq;
  logic sckIn = 1'b0, mosiIn = 1'b0, misoIn = 1'b0, ssN = 1'b1;
  logic sckOut, sckOe, mosiOut, mosiOe, misoOut, misoOe;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spiPort dut (
    .clk(clk), .rstN(rstN), .enable(enable), .masterSel(masterSel),
    .cpol(cpol), .cpha(cpha), .wide(wide), .lsbFirst(lsbFirst),
    .irqEnable(irqEnable), .baudDiv(baudDiv), .txData(txData),
    .txWrite(txWrite), .flagClear(flagClear), .rxData(rxData),
    .doneFlag(doneFlag), .irq(irq), .sckIn(sckIn), .sckOut(sckOut),
    .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic bitOf(input logic [15:0] w, input int k, input int n, input logic lsb);
    if (k >= n) return 1'b0;
    return lsb ? w[k] : w[n-1-k];
  endfunction

  function automatic logic [15:0] maskN(input logic [15:0] w, input int n);
    return (n == 16) ? w : (w & 16'h00FF);
  endfunction

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearFlag();
    flagClear = 1'b1;
    @(negedge clk);
    flagClear = 1'b0;
    @(negedge clk);
    check(doneFlag == 1'b0, "R7 flag clear", doneFlag, 0);
  endtask

  // Bench plays the slave while the DUT is master.
  task automatic masterXfer(input int cfg, input int div, input logic [15:0] tx, input logic [15:0] mw);
    int n, edges, gap, badGap, sIdx, mIdx, t;
    logic prev, lead;
    logic [15:0] got;
    cpol = cfg[0]; cpha = cfg[1]; wide = cfg[2]; lsbFirst = cfg[3];
    irqEnable = cfg[0] ^ cfg[3];
    n = wide ? 16 : 8;
    masterSel = 1'b1; enable = 1'b1; baudDiv = 8'(div);
    misoIn = cpha ? 1'b0 : bitOf(mw, 0, n, lsbFirst);
    waitClk(3);
    check(sckOut == cpol, "R1 idle level", sckOut, cpol);
    check(sckOe && mosiOe && !misoOe, "R4 master enables", {sckOe, mosiOe, misoOe}, 3'b110);
    txData = tx; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    prev = sckOut; edges = 0; gap = 0; badGap = 0; sIdx = 0; got = '0; t = 0;
    mIdx = cpha ? 0 : 1;
    while (!doneFlag && t < 4000) begin
      @(negedge clk);
      t++; gap++;
      if (sckOut != prev) begin
        edges++;
        if (edges > 1 && gap != div + 1) badGap++;
        gap = 0;
        lead = (sckOut != cpol);
        if (cpha ? !lead : lead) begin
          if (sIdx < n) got[lsbFirst ? sIdx : n-1-sIdx] = mosiOut;
          sIdx++;
        end
        if (cpha ? lead : !lead) begin
          misoIn = bitOf(mw, mIdx, n, lsbFirst);
          mIdx++;
        end
        prev = sckOut;
      end
    end
    check(edges == 2*n, "R1 edge count", edges, 2*n);
    check(badGap == 0, "R1 divisor rate", badGap, 0);
    check(sckOut == cpol, "R1 return to idle", sckOut, cpol);
    check(got == maskN(tx, n), "R2 R3 master out bits", got, maskN(tx, n));
    check(rxData == maskN(mw, n), "R3 R7 master rx word", rxData, maskN(mw, n));
    check(doneFlag == 1'b1, "R7 master flag", doneFlag, 1);
    check(irq == irqEnable, "R8 irq follows flag", irq, irqEnable);
    clearFlag();
    check(irq == 1'b0, "R8 irq after clear", irq, 0);
  endtask

  // Bench plays the master while the DUT is slave. nBits < word length aborts.
  task automatic slaveXfer(input int cfg, input int div, input logic [15:0] tx,
                           input logic [15:0] mw, input int nBits, input bit en);
    localparam int H = 6;
    int n;
    logic [15:0] got, rxBefore;
    bit full;
    cpol = cfg[0]; cpha = cfg[1]; wide = cfg[2]; lsbFirst = cfg[3];
    irqEnable = 1'b1;
    n = wide ? 16 : 8;
    full = (nBits >= n);
    masterSel = 1'b0; enable = en; baudDiv = 8'(div);
    sckIn = cpol; ssN = 1'b1;
    txData = tx; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    mosiIn = cpha ? 1'b0 : bitOf(mw, 0, n, lsbFirst);
    waitClk(4);
    rxBefore = rxData;
    check(!misoOe && !sckOe && !mosiOe, "R4 slave idle enables", {sckOe, mosiOe, misoOe}, 0);
    ssN = 1'b0;
    waitClk(H);
    check(misoOe == en, "R4 R5 miso enable", misoOe, en);
    check(!sckOe && !mosiOe, "R4 slave drives no sck", {sckOe, mosiOe}, 0);
    got = '0;
    for (int k = 0; k < nBits && k < n; k++) begin
      if (!cpha) begin
        got[lsbFirst ? k : n-1-k] = misoOut;
        sckIn = ~cpol;
        waitClk(H);
        sckIn = cpol;
        mosiIn = bitOf(mw, k+1, n, lsbFirst);
        waitClk(H);
      end else begin
        sckIn = ~cpol;
        mosiIn = bitOf(mw, k, n, lsbFirst);
        waitClk(H);
        got[lsbFirst ? k : n-1-k] = misoOut;
        sckIn = cpol;
        waitClk(H);
      end
    end
    waitClk(4);
    ssN = 1'b1;
    waitClk(5);
    if (!en) begin
      check(doneFlag == 1'b0, "R5 disabled no flag", doneFlag, 0);
    end else if (full) begin
      check(doneFlag == 1'b1, "R7 slave flag", doneFlag, 1);
      check(irq == 1'b1, "R8 slave irq", irq, 1);
      check(got == maskN(tx, n), "R3 R10 slave out bits", got, maskN(tx, n));
      check(rxData == maskN(mw, n), "R3 R6 R7 slave rx word", rxData, maskN(mw, n));
      clearFlag();
    end else begin
      check(doneFlag == 1'b0, "R9 abort no flag", doneFlag, 0);
      check(rxData == rxBefore, "R9 abort keeps rx", rxData, rxBefore);
    end
  endtask

  initial begin
    waitClk(3);
    // R11 reset state
    check(doneFlag == 1'b0 && irq == 1'b0, "R11 reset flag/irq", {doneFlag, irq}, 0);
    check(rxData == 16'h0, "R11 reset rx", rxData, 0);
    check(!sckOe && !mosiOe && !misoOe, "R11 reset enables", {sckOe, mosiOe, misoOe}, 0);
    rstN = 1'b1;
    waitClk(2);

    for (int c = 0; c < 16; c++)
      masterXfer(c, c % 3, 16'hA5C3 ^ 16'(c * 16'h1357), 16'h3C96 ^ 16'(c * 16'h0F21));

    for (int c = 0; c < 16; c++)
      slaveXfer(c, (c * 37) % 256, 16'h5A3C ^ 16'(c * 16'h2468), 16'hC3E1 ^ 16'(c * 16'h1F0B), 16, 1'b1);

    // R6 same slave transfer with extreme divisor values
    slaveXfer(5, 0,   16'h1234, 16'h00A7, 16, 1'b1);
    slaveXfer(5, 255, 16'h1234, 16'h00A7, 16, 1'b1);

    // R9 abort mid-word, then a full word must still align
    slaveXfer(4, 0, 16'hBEEF, 16'h7E81, 5, 1'b1);
    slaveXfer(6, 0, 16'hBEEF, 16'h7E81, 3, 1'b1);
    slaveXfer(4, 0, 16'hF00D, 16'h4C2B, 16, 1'b1);

    // R5 disabled slave
    slaveXfer(0, 0, 16'h00FF, 16'h0055, 16, 1'b0);

    // R4 slave never starts on its own
    enable = 1'b1; masterSel = 1'b0; ssN = 1'b1; sckIn = 1'b0;
    txData = 16'hFFFF; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    waitClk(60);
    check(doneFlag == 1'b0, "R4 slave no self start", doneFlag, 0);
    check(sckOe == 1'b0, "R4 slave sck released", sckOe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule